// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four SRAM Port

This block is a synthesizable, cycle-level model of a static RAM that has separate read and write ports. Each transfer is a fixed burst of four words. The block runs on one clock at twice the command rate. An input phase flag, `k_rise`, marks which edges are the command-clock rising edges (flag high) and which are the mid-cycle edges (flag low). A command cycle is two clock edges: a rising edge followed by a mid-cycle edge. Commands are accepted only on rising edges. Data beats move on every edge, so four beats fill two command cycles.

Each port has an active-low select and its own burst address. A write supplies four data words, each with its own byte-lane enables. A read returns four words on `q`, qualified by `q_valid`. `q_oe` stands in for a tri-state output driver. Both ports can be busy at the same time. A start request on a port is refused if that port accepted a start on the immediately preceding rising edge. The storage is an internal array split into byte lanes, so that a block RAM with read-before-write ports can hold it.

Top module: `qdr_b4_sram`

## Requirements
- R1: A write starts when `wr_sel_n` is low on an edge with `k_rise` high (call it edge e). `wr_addr` is latched on edge e. The burst writes the `wr_data` beats present on clock edges e+2, e+3, e+4 and e+5 to addresses A, A+1, A+2 and A+3.
- R2: A read starts when `rd_sel_n` is low on an edge with `k_rise` high (edge e), latching `rd_addr` as A. The word at A+k is on `q` with `q_valid` and `q_oe` high during the clock cycle that follows edge e+3+k, for k = 0 to 3.
- R3: Burst addresses are computed modulo the array depth (2^ADDR_W words). A burst that starts at address 62 of 64 therefore touches 62, 63, 0 and 1.
- R4: During a write beat, bit i of `wr_be` set to 1 updates byte lane i (`wr_data[8i+7:8i]`) of the addressed word. Bit i set to 0 leaves that lane unchanged.
- R5: A start request on a port is ignored when that same port accepted a start on the preceding `k_rise` edge. An ignored read produces no beats. An ignored write changes no word.
- R6: On clock cycles that carry no read beat, `q_valid` and `q_oe` are low and `q` is zero. `wr_data` present on an edge with no write burst active changes no word.
- R7: While `rst` is high, and on the cycle after it, `q_valid` and `q_oe` are low and `q` is zero. No burst is pending on either port when reset ends.
- R8: A read and a write can both start on the same `k_rise` edge, and both bursts then run concurrently.
- R9: A read beat sampled on the same edge as a write beat to the same address returns the word as it was before that write. A read beat sampled on a later edge returns the written word.
- R10: `rd_sel_n` and `wr_sel_n` are ignored on edges where `k_rise` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the command rate |
| rst | input | 1 | Synchronous active-high reset |
| k_rise | input | 1 | High on the edge that is a command-clock rising edge, low on the mid-cycle edge |
| rd_sel_n | input | 1 | Active-low read start request |
| rd_addr | input | ADDR_W | Read burst start address |
| wr_sel_n | input | 1 | Active-low write start request |
| wr_addr | input | ADDR_W | Write burst start address |
| wr_data | input | DATA_W | Write data beat |
| wr_be | input | DATA_W/8 | Byte-lane write enables for the current beat, active high |
| q | output | DATA_W | Read data beat, zero when not driven |
| q_valid | output | 1 | High while `q` carries a read beat |
| q_oe | output | 1 | Output-enable stand-in for a tri-state driver |

## Verification
A sequencer stuck in a wrong state shows at the ports within a few edges. A lost or extra launch changes `q_valid` one edge after the affected beat is sampled, at most four edges after the start. An address counter that is off shows up as a wrong word on that same first beat, or it corrupts memory that a later read exposes. A stale back-to-back guard shows as a phantom four-beat burst, or a missing one, starting three edges after the refused request. Bad write-lane or collision ordering stays hidden until a read reaches the affected word, so the test reads back every word it writes.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int BURST_LEN = 4;
  localparam int BEAT_W = $clog2(BURST_LEN);
  typedef logic [BEAT_W-1:0] beat_t;
  localparam beat_t LAST_BEAT = beat_t'(BURST_LEN - 1);
endpackage

// File: rtl/qdr_burst_seq.sv
// Per-port start detection and beat sequencing. A start accepted on a
// command edge is parked for one command cycle, then launched; the launch
// edge carries beat 0 and the next three edges carry beats 1..3.
module qdr_burst_seq
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              k_rise,
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              start,
  output logic              op_v,
  output beat_t             op_beat,
  output logic [ADDR_W-1:0] op_addr
);
  logic              prev_start;
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic              act_v;
  beat_t             act_beat;
  logic [ADDR_W-1:0] act_base;
  logic              launch;

  always_comb begin
    start   = k_rise && !sel_n && !prev_start;
    launch  = k_rise && pend_v;
    op_v    = launch || act_v;
    op_beat = launch ? '0 : act_beat;
    op_addr = launch ? pend_addr : act_base + ADDR_W'(act_beat);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_start <= 1'b0;
      pend_v     <= 1'b0;
      pend_addr  <= '0;
      act_v      <= 1'b0;
      act_beat   <= '0;
      act_base   <= '0;
    end else begin
      if (k_rise) begin
        prev_start <= start;
        pend_v     <= start;
      end
      if (start) pend_addr <= addr;
      if (launch) begin
        act_v    <= 1'b1;
        act_base <= pend_addr;
        act_beat <= beat_t'(1);
      end else if (act_v) begin
        act_beat <= act_beat + beat_t'(1);
        if (act_beat == LAST_BEAT) act_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qdr_lane_ram.sv
// One byte lane of storage, simple dual port, read-before-write.
module qdr_lane_ram #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/qdr_rd_out.sv
// Output stage: aligns the valid flag with the RAM read latency and
// registers the beat, forcing zero while the port is released.
module qdr_rd_out #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_v,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] q,
  output logic              q_valid,
  output logic              q_oe
);
  logic v_s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_s1    <= 1'b0;
      q       <= '0;
      q_valid <= 1'b0;
      q_oe    <= 1'b0;
    end else begin
      v_s1    <= rd_v;
      q       <= v_s1 ? rd_word : '0;
      q_valid <= v_s1;
      q_oe    <= v_s1;
    end
  end
endmodule

// File: rtl/qdr_b4_sram.sv
module qdr_b4_sram
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     k_rise,
  input  logic                     rd_sel_n,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic                     wr_sel_n,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [DATA_W/LANE_W-1:0] wr_be,
  output logic [DATA_W-1:0]        q,
  output logic                     q_valid,
  output logic                     q_oe
);
  localparam int LANES = DATA_W / LANE_W;

  logic              rd_start, rd_op_v;
  beat_t             rd_op_beat;
  logic [ADDR_W-1:0] rd_op_addr;
  logic              wr_start, wr_op_v;
  beat_t             wr_op_beat;
  logic [ADDR_W-1:0] wr_op_addr;
  logic [DATA_W-1:0] rd_word;

  qdr_burst_seq #(.ADDR_W(ADDR_W)) rd_seq_i (
    .clk(clk), .rst(rst), .k_rise(k_rise), .sel_n(rd_sel_n), .addr(rd_addr),
    .start(rd_start), .op_v(rd_op_v), .op_beat(rd_op_beat), .op_addr(rd_op_addr)
  );

  qdr_burst_seq #(.ADDR_W(ADDR_W)) wr_seq_i (
    .clk(clk), .rst(rst), .k_rise(k_rise), .sel_n(wr_sel_n), .addr(wr_addr),
    .start(wr_start), .op_v(wr_op_v), .op_beat(wr_op_beat), .op_addr(wr_op_addr)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    qdr_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) ram_i (
      .clk(clk),
      .we(wr_op_v && wr_be[l]),
      .waddr(wr_op_addr),
      .wdata(wr_data[l*LANE_W +: LANE_W]),
      .re(rd_op_v),
      .raddr(rd_op_addr),
      .rdata(rd_word[l*LANE_W +: LANE_W])
    );
  end

  qdr_rd_out #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst(rst), .rd_v(rd_op_v), .rd_word(rd_word),
    .q(q), .q_valid(q_valid), .q_oe(q_oe)
  );
endmodule

// File: rtl/qdr_b4_sram_chk.sv
module qdr_b4_sram_chk
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_start,
  input logic              rd_op_v,
  input beat_t             rd_op_beat,
  input logic              wr_start,
  input logic              wr_op_v,
  input beat_t             wr_op_beat,
  input logic [ADDR_W-1:0] wr_op_addr,
  input logic [DATA_W-1:0] q,
  input logic              q_valid,
  input logic              q_oe
);
  assert_wr_first_beat_R1: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> ##2 (wr_op_v && wr_op_beat == '0));

  assert_wr_last_beat_R1: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> ##5 (wr_op_v && wr_op_beat == LAST_BEAT));

  assert_rd_first_beat_R2: assert property (@(posedge clk) disable iff (rst)
    rd_start |-> ##2 (rd_op_v && rd_op_beat == '0));

  assert_rd_to_q_R2: assert property (@(posedge clk) disable iff (rst)
    rd_op_v |=> ##1 (q_valid && q_oe));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_op_v && wr_op_beat != '0) |-> wr_op_addr == ADDR_W'($past(wr_op_addr) + 1'b1));

  assert_no_rd_repeat_R5: assert property (@(posedge clk) disable iff (rst)
    rd_start |-> ##2 !rd_start);

  assert_no_wr_repeat_R5: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> ##2 !wr_start);

  assert_released_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !q_oe |-> q == '0);

  assert_reset_quiet_R7: assert property (@(posedge clk)
    rst |=> (!q_valid && !q_oe));
endmodule

bind qdr_b4_sram qdr_b4_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst),
  .rd_start(rd_start), .rd_op_v(rd_op_v), .rd_op_beat(rd_op_beat),
  .wr_start(wr_start), .wr_op_v(wr_op_v), .wr_op_beat(wr_op_beat),
  .wr_op_addr(wr_op_addr),
  .q(q), .q_valid(q_valid), .q_oe(q_oe)
);

// File: tb/qdr_b4_sram_tb_top.sv
`timescale 1ns/1ps
module qdr_b4_sram_tb_top;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic k_rise = 1'b1;
  logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] wr_be = '0;
  logic [DW-1:0] q;
  logic q_valid, q_oe;

  always #2.5ns clk = ~clk;

  qdr_b4_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(8)) dut_i (
    .clk(clk), .rst(rst), .k_rise(k_rise), .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
    .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .q(q), .q_valid(q_valid), .q_oe(q_oe)
  );

  int checks = 0, errors = 0;
  int e_cnt = 0;
  string cur_tag = "R7";

  // copies of the inputs seen on the last edge
  logic s_rst, s_rise, s_rsel, s_wsel;
  logic [AW-1:0] s_raddr, s_waddr;
  logic [DW-1:0] s_wd;
  logic [1:0] s_be;

  always @(posedge clk) begin
    e_cnt  <= e_cnt + 1;
    s_rst  <= rst;     s_rise <= k_rise;
    s_rsel <= rd_sel_n; s_wsel <= wr_sel_n;
    s_raddr <= rd_addr; s_waddr <= wr_addr;
    s_wd <= wr_data;   s_be <= wr_be;
  end

  // scoreboard state
  logic [DW-1:0] mdl [DEPTH];
  int r_at [int];
  int w_at [int];
  int eq_edge [$];
  logic [DW-1:0] eq_data [$];
  string eq_tag [$];
  logic m_rprev, m_wprev;
  logic [DW-1:0] dtab [int];
  logic [1:0] btab [int];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (edge %0d)", tag, act, exp, e_cnt);
    end
  endtask

  // model and monitor: step for the edge that just happened
  always @(negedge clk) begin
    int n;
    logic rs, ws;
    n = e_cnt - 1;
    if (e_cnt > 0) begin
      if (s_rst) begin
        r_at.delete(); w_at.delete();
        m_rprev = 1'b0; m_wprev = 1'b0;
      end else begin
        // monitor outputs produced by edge n
        if (eq_edge.size() > 0 && eq_edge[0] == n) begin
          chk(q_valid && q_oe && q == eq_data[0], eq_tag[0], q, eq_data[0]);
          void'(eq_edge.pop_front()); void'(eq_data.pop_front()); void'(eq_tag.pop_front());
        end else begin
          chk(!q_valid && !q_oe && q == '0, {cur_tag, " idle R6"}, q, '0);
        end
        // starts on edge n
        rs = s_rise && !s_rsel && !m_rprev;
        ws = s_rise && !s_wsel && !m_wprev;
        if (s_rise) begin m_rprev = rs; m_wprev = ws; end
        for (int k = 0; k < 4; k++) begin
          if (rs) r_at[n+2+k] = (int'(s_raddr) + k) % DEPTH;
          if (ws) w_at[n+2+k] = (int'(s_waddr) + k) % DEPTH;
        end
        // read before write on the same edge (R9)
        if (r_at.exists(n)) begin
          eq_edge.push_back(n + 1); eq_data.push_back(mdl[r_at[n]]); eq_tag.push_back(cur_tag);
          r_at.delete(n);
        end
        if (w_at.exists(n)) begin
          if (s_be[0]) mdl[w_at[n]][7:0]  = s_wd[7:0];
          if (s_be[1]) mdl[w_at[n]][15:8] = s_wd[15:8];
          w_at.delete(n);
        end
      end
    end
  end

  task automatic put_data(input int n);
    if (dtab.exists(n)) begin wr_data = dtab[n]; wr_be = btab[n]; end
    else begin wr_data = DW'(n * 16'h3b1); wr_be = 2'b11; end
  endtask

  task automatic kcycle(input bit rs, input logic [AW-1:0] ra, input bit ws, input logic [AW-1:0] wa,
                        input logic [63:0] wd, input logic [7:0] wb, input bit sched, input bit fall_low);
    int n;
    n = e_cnt;
    k_rise = 1'b1; rd_sel_n = rs; wr_sel_n = ws; rd_addr = ra; wr_addr = wa;
    put_data(n);
    if (sched) for (int k = 0; k < 4; k++) begin
      dtab[n+2+k] = wd[k*16 +: 16];
      btab[n+2+k] = wb[k*2 +: 2];
    end
    @(negedge clk);
    n = e_cnt;
    k_rise = 1'b0;
    rd_sel_n = !fall_low; wr_sel_n = !fall_low;
    put_data(n);
    @(negedge clk);
  endtask

  task automatic nop(input int cnt);
    for (int i = 0; i < cnt; i++) kcycle(1, '0, 1, '0, '0, '0, 0, 0);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] b);
    kcycle(1, '0, 0, a, d, b, 1, 0);
  endtask
  task automatic rd(input logic [AW-1:0] a);
    kcycle(0, a, 1, '0, '0, '0, 0, 0);
  endtask

  bit done = 0;
  initial begin
    #500000ns;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R7: outputs quiet during reset
    chk(!q_valid && !q_oe && q == '0, "R7 reset", q, '0);
    rst = 1'b0;
    k_rise = 1'b1;
    chk(!q_valid && !q_oe && q == '0, "R7 after reset", q, '0);
    nop(2);

    cur_tag = "R1 fill";
    for (int b = 0; b < DEPTH / 4; b++) begin
      logic [63:0] d;
      for (int k = 0; k < 4; k++) d[k*16 +: 16] = 16'h5a00 ^ 16'((b*4 + k) * 16'h0101);
      wr(AW'(b*4), d, 8'hff);
      nop(1);
    end
    nop(3);

    cur_tag = "R2 read";
    rd(0); nop(1); rd(8); nop(1); rd(33); nop(4);
    rd(16); rd(1); nop(4);          // second request back-to-back ignored (R5)

    cur_tag = "R3 wrap";
    wr(6'd62, 64'h1111_2222_3333_4444, 8'hff); nop(2);
    rd(6'd62); nop(1); rd(6'd63); nop(4);

    cur_tag = "R4 byte lanes";
    wr(6'd10, 64'hAAAA_BBBB_CCCC_DDDD, 8'b11_00_10_01); nop(2);
    rd(6'd10); nop(4);

    cur_tag = "R5 repeat";
    rd(6'd20); rd(6'd40); nop(4);
    wr(6'd28, 64'h0f0f_1e1e_2d2d_3c3c, 8'hff);
    kcycle(1, '0, 0, 6'd44, '0, '0, 0, 0);   // ignored write
    nop(3);
    rd(6'd28); nop(1); rd(6'd44); nop(4);

    cur_tag = "R8 concurrent";
    kcycle(0, 6'd36, 0, 6'd52, 64'h7777_6666_5555_4444, 8'hff, 1, 0);
    nop(3); rd(6'd52); nop(4);

    cur_tag = "R9 collision";
    kcycle(0, 6'd12, 0, 6'd12, 64'h9999_8888_7777_6666, 8'hff, 1, 0);
    nop(3); rd(6'd12); nop(4);
    wr(6'd4, 64'h1234_5678_9abc_def0, 8'hff); rd(6'd4); nop(4);

    cur_tag = "R10 mid-edge";
    kcycle(1, 6'd24, 1, 6'd24, '0, '0, 0, 1);
    nop(4); rd(6'd24); nop(4);

    cur_tag = "R6 stray data";
    nop(3); rd(6'd44); nop(4);

    chk(eq_edge.size() == 0, "R2 drain", DW'(eq_edge.size()), '0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule